// File: doc/BRIEF.md
# Multi-Record Triggered Capture Sequencer

This block controls how a parallel digital sample stream is captured into record memory. After a start trigger it opens a record and writes incoming samples into a circular window, which holds the samples from before the trigger. It accepts a reference trigger only once a programmed number of those earlier samples is in the window. It then writes a programmed number of later samples and closes the record. It reports the window address at which the later samples began, so that a reader can rebuild the record in time order. It repeats this for a programmed number of records. Between records it can wait for an advance trigger. It emits single-cycle events when it is ready for a start, when it is ready for an advance, and when a record ends.

Each trigger (start, reference, advance) is taken from a hardware line, from a software pulse, or is switched off. A hardware line passes through a two-flop synchroniser and then edge detection with selectable polarity. A fourth hardware line acts as a level-sensitive pause that holds capture while it sits at its active level. The memory, any pattern-match trigger source and host readout are outside this block. It drives only the write address, the data, the enable and the record index.

Top module: `rec_acq_ctrl`

## Requirements
- R1: In idle the block writes nothing until a start trigger is seen. Trigger source codes are 2'b00 for the hardware line, 2'b01 for the software pulse, and 2'b10 or 2'b11 for off. A hardware trigger edge is detected after a two-flop synchroniser. Polarity bit 1 selects rising and 0 selects falling (bit 0 start, bit 1 reference, bit 2 advance). Hardware line 0 is start, 1 is reference, 2 is advance and 3 is pause.
- R2: A reference trigger is ignored until at least `cfg_pre` samples have been written since the record began. An ignored reference trigger is not remembered.
- R3: Each record writes from window address 0 upward. Addresses wrap modulo 2^ADDR_W. `wr_en`, `wr_addr` and `wr_data` appear one clock after the sample is presented.
- R4: After the reference trigger, exactly `cfg_post` further samples are written (0 is allowed), then the record closes. Samples arriving after that are not written unless a new record has begun.
- R5: When a record closes, `evt_eor` pulses for one cycle. In the same cycle `eor_ref_addr` shows the window address of the first sample after the reference trigger.
- R6: With `cfg_pause_on` set, while the synchronised pause line equals `cfg_pause_lvl`, no sample is written and no count advances.
- R7: After `cfg_nrec` records (0 treated as 1) the block returns to idle. `evt_rdy_start` pulses when it does so, and also in the first cycle after reset.
- R8: With the advance source not off, the block waits between records and pulses `evt_rdy_adv` as the earlier record closes. Samples in that wait are not written.
- R9: A trigger whose source is off does not hold the sequence. A reference trigger that is off fires as soon as the pre-trigger count is met. An advance trigger that is off starts the next record at once.
- R10: `wr_rec` carries the zero-based index of the record that each write belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample present this cycle |
| smp_data | input | DATA_W | Sample value |
| trg_hw | input | 4 | Hardware lines: start, reference, advance, pause |
| trg_sw | input | 3 | Software pulses: start, reference, advance |
| cfg_src_start | input | 2 | Start trigger source code |
| cfg_src_ref | input | 2 | Reference trigger source code |
| cfg_src_adv | input | 2 | Advance trigger source code |
| cfg_edge_pol | input | 3 | Edge polarity per trigger, 1 = rising |
| cfg_pause_on | input | 1 | Enable the pause line |
| cfg_pause_lvl | input | 1 | Level at which the pause line holds capture |
| cfg_pre | input | ADDR_W+1 | Pre-trigger sample count |
| cfg_post | input | ADDR_W+1 | Post-trigger sample count |
| cfg_nrec | input | 31 | Records per acquisition |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Window address of the write |
| wr_data | output | DATA_W | Data to write |
| wr_rec | output | 31 | Record index of the write |
| evt_rdy_start | output | 1 | Ready-for-start event pulse |
| evt_rdy_adv | output | 1 | Ready-for-advance event pulse |
| evt_eor | output | 1 | End-of-record event pulse |
| eor_ref_addr | output | ADDR_W | Address of the first post-trigger sample |

## Verification
The main function is tried with a table of pre-count, post-count and fill-length triples. These include a fill that wraps the window, a window filled entirely by pre-trigger samples with no post samples, and a record made only of post-trigger samples. Together they separate wrong wrap arithmetic, wrong latching of the reference address, and off-by-one errors in the post count. Directed runs then fire a reference trigger too early, hold a pause level, and use a falling-edge hardware start against a rising-edge hardware reference. They also run multi-record acquisitions with the advance trigger both waited for and switched off, which shows whether events, record indices and discarded samples follow the sequence.

// File: rtl/rec_acq_pkg.sv
package rec_acq_pkg;

    localparam int REC_W    = 31;
    localparam int N_HW     = 4;
    localparam int N_EDGE   = 3;
    localparam int T_START  = 0;
    localparam int T_REF    = 1;
    localparam int T_ADV    = 2;
    localparam int T_PAUSE  = 3;

    localparam logic [1:0] SRC_HW = 2'b00;
    localparam logic [1:0] SRC_SW = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2,
        ST_WADV = 2'd3
    } acq_state_e;

    typedef struct packed {
        logic hit_start;
        logic hit_ref;
        logic hit_adv;
        logic paused;
    } trig_ev_t;

    function automatic logic edge_seen(logic cur, logic prev, logic rising);
        return rising ? (cur & ~prev) : (~cur & prev);
    endfunction

    function automatic logic src_waits(logic [1:0] src);
        return ~src[1];
    endfunction

endpackage

// File: rtl/rec_acq_sync.sv
module rec_acq_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/rec_acq_qual.sv
module rec_acq_qual
    import rec_acq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] src,
    input  logic       rising,
    input  logic       lvl,
    input  logic       sw,
    output logic       hit
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    always_comb begin
        if (!src_waits(src))   hit = 1'b1;
        else if (src == SRC_SW) hit = sw;
        else                   hit = edge_seen(lvl, prev, rising);
    end
endmodule

// File: rtl/rec_acq_seq.sv
module rec_acq_seq
    import rec_acq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  trig_ev_t          ev,
    input  logic              adv_wait,
    input  logic              smp_en,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [ADDR_W:0]   cfg_pre,
    input  logic [ADDR_W:0]   cfg_post,
    input  logic [REC_W-1:0]  cfg_nrec,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [REC_W-1:0]  wr_rec,
    output logic              evt_rdy_start,
    output logic              evt_rdy_adv,
    output logic              evt_eor,
    output logic [ADDR_W-1:0] eor_ref_addr
);
    localparam int CNT_W = ADDR_W + 1;

    acq_state_e         st, st_n;
    logic [ADDR_W-1:0]  ptr, ptr_n, refa, refa_n;
    logic [CNT_W-1:0]   pre_cnt, pre_n, post_cnt, post_n;
    logic [REC_W-1:0]   rec_idx, rec_n;
    logic               wr, fin, go_idle, go_wadv, last, fresh;

    assign last = ({1'b0, rec_idx} + 32'd1) >= {1'b0, cfg_nrec};

    always_comb begin
        st_n    = st;
        ptr_n   = ptr;
        pre_n   = pre_cnt;
        post_n  = post_cnt;
        rec_n   = rec_idx;
        refa_n  = refa;
        wr      = 1'b0;
        fin     = 1'b0;
        go_idle = 1'b0;
        go_wadv = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (ev.hit_start) begin
                    st_n   = ST_PRE;
                    ptr_n  = '0;
                    pre_n  = '0;
                    rec_n  = '0;
                end
            end
            ST_PRE: begin
                wr = smp_en & ~ev.paused;
                if (wr) begin
                    ptr_n = ptr + ADDR_W'(1);
                    if (pre_cnt < cfg_pre) pre_n = pre_cnt + CNT_W'(1);
                end
                if (ev.hit_ref && (pre_cnt >= cfg_pre)) begin
                    st_n   = ST_POST;
                    refa_n = ptr_n;
                    post_n = '0;
                end
            end
            ST_POST: begin
                if (post_cnt >= cfg_post) begin
                    fin = 1'b1;
                    if (last) begin
                        st_n    = ST_IDLE;
                        go_idle = 1'b1;
                    end else begin
                        rec_n = rec_idx + REC_W'(1);
                        if (adv_wait) begin
                            st_n    = ST_WADV;
                            go_wadv = 1'b1;
                        end else begin
                            st_n  = ST_PRE;
                            ptr_n = '0;
                            pre_n = '0;
                        end
                    end
                end else begin
                    wr = smp_en & ~ev.paused;
                    if (wr) begin
                        ptr_n  = ptr + ADDR_W'(1);
                        post_n = post_cnt + CNT_W'(1);
                    end
                end
            end
            ST_WADV: begin
                if (ev.hit_adv) begin
                    st_n  = ST_PRE;
                    ptr_n = '0;
                    pre_n = '0;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= ST_IDLE;
            ptr           <= '0;
            refa          <= '0;
            pre_cnt       <= '0;
            post_cnt      <= '0;
            rec_idx       <= '0;
            fresh         <= 1'b1;
            wr_en         <= 1'b0;
            wr_addr       <= '0;
            wr_data       <= '0;
            wr_rec        <= '0;
            evt_rdy_start <= 1'b0;
            evt_rdy_adv   <= 1'b0;
            evt_eor       <= 1'b0;
            eor_ref_addr  <= '0;
        end else begin
            st            <= st_n;
            ptr           <= ptr_n;
            refa          <= refa_n;
            pre_cnt       <= pre_n;
            post_cnt      <= post_n;
            rec_idx       <= rec_n;
            fresh         <= 1'b0;
            wr_en         <= wr;
            wr_addr       <= ptr;
            wr_data       <= smp_data;
            wr_rec        <= rec_idx;
            evt_rdy_start <= go_idle | fresh;
            evt_rdy_adv   <= go_wadv;
            evt_eor       <= fin;
            if (fin) eor_ref_addr <= refa;
        end
    end
endmodule

// File: rtl/rec_acq_ctrl.sv
module rec_acq_ctrl
    import rec_acq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_en,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [3:0]        trg_hw,
    input  logic [2:0]        trg_sw,
    input  logic [1:0]        cfg_src_start,
    input  logic [1:0]        cfg_src_ref,
    input  logic [1:0]        cfg_src_adv,
    input  logic [2:0]        cfg_edge_pol,
    input  logic              cfg_pause_on,
    input  logic              cfg_pause_lvl,
    input  logic [ADDR_W:0]   cfg_pre,
    input  logic [ADDR_W:0]   cfg_post,
    input  logic [30:0]       cfg_nrec,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [30:0]       wr_rec,
    output logic              evt_rdy_start,
    output logic              evt_rdy_adv,
    output logic              evt_eor,
    output logic [ADDR_W-1:0] eor_ref_addr
);
    logic [N_HW-1:0]        lvl;
    logic [N_EDGE-1:0]      hit;
    logic [N_EDGE-1:0][1:0] src;
    trig_ev_t               ev;

    assign src[T_START] = cfg_src_start;
    assign src[T_REF]   = cfg_src_ref;
    assign src[T_ADV]   = cfg_src_adv;

    rec_acq_sync #(.N(N_HW), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (trg_hw),
        .dout(lvl)
    );

    for (genvar g = 0; g < N_EDGE; g++) begin : g_qual
        rec_acq_qual u_qual (
            .clk   (clk),
            .rst   (rst),
            .src   (src[g]),
            .rising(cfg_edge_pol[g]),
            .lvl   (lvl[g]),
            .sw    (trg_sw[g]),
            .hit   (hit[g])
        );
    end

    assign ev.hit_start = hit[T_START];
    assign ev.hit_ref   = hit[T_REF];
    assign ev.hit_adv   = hit[T_ADV];
    assign ev.paused    = cfg_pause_on & (lvl[T_PAUSE] == cfg_pause_lvl);

    rec_acq_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .adv_wait     (src_waits(cfg_src_adv)),
        .smp_en       (smp_en),
        .smp_data     (smp_data),
        .cfg_pre      (cfg_pre),
        .cfg_post     (cfg_post),
        .cfg_nrec     (cfg_nrec),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wr_rec       (wr_rec),
        .evt_rdy_start(evt_rdy_start),
        .evt_rdy_adv  (evt_rdy_adv),
        .evt_eor      (evt_eor),
        .eor_ref_addr (eor_ref_addr)
    );
endmodule

// File: rtl/rec_acq_chk.sv
module rec_acq_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [30:0]       wr_rec,
    input logic              evt_eor,
    input logic              evt_rdy_adv,
    input logic              evt_rdy_start,
    input logic              pause_in,
    input logic              pause_on,
    input logic              pause_lvl
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)           age <= '0;
        else if (age != 3) age <= age + 2'd1;
    end

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en) && wr_rec == $past(wr_rec))
        |-> wr_addr == $past(wr_addr) + ADDR_W'(1));

    assert_no_write_at_close_R4: assert property (@(posedge clk) disable iff (rst)
        evt_eor |-> !wr_en);

    assert_pause_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        (age == 3 && pause_on && $past(pause_on) && pause_in == pause_lvl
         && $past(pause_in) == pause_lvl && $past(pause_in, 2) == pause_lvl)
        |=> !wr_en);

    assert_ready_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(evt_rdy_start && evt_rdy_adv));

    assert_adv_with_close_R8: assert property (@(posedge clk) disable iff (rst)
        evt_rdy_adv |-> evt_eor);
endmodule

bind rec_acq_ctrl rec_acq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_rec       (wr_rec),
    .evt_eor      (evt_eor),
    .evt_rdy_adv  (evt_rdy_adv),
    .evt_rdy_start(evt_rdy_start),
    .pause_in     (trg_hw[3]),
    .pause_on     (cfg_pause_on),
    .pause_lvl    (cfg_pause_lvl)
);

// File: tb/rec_acq_ctrl_tb.sv
module rec_acq_ctrl_tb;
    localparam int AW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_en = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic [3:0]    trg_hw = '0;
    logic [2:0]    trg_sw = '0;
    logic [1:0]    cfg_src_start = 2'b01, cfg_src_ref = 2'b01, cfg_src_adv = 2'b10;
    logic [2:0]    cfg_edge_pol = 3'b111;
    logic          cfg_pause_on = 1'b0, cfg_pause_lvl = 1'b1;
    logic [AW:0]   cfg_pre = '0, cfg_post = '0;
    logic [30:0]   cfg_nrec = 31'd1;
    logic          wr_en, evt_rdy_start, evt_rdy_adv, evt_eor;
    logic [AW-1:0] wr_addr, eor_ref_addr;
    logic [DW-1:0] wr_data;
    logic [30:0]   wr_rec;

    always #5 clk = ~clk;

    rec_acq_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .smp_en(smp_en), .smp_data(smp_data),
        .trg_hw(trg_hw), .trg_sw(trg_sw), .cfg_src_start(cfg_src_start),
        .cfg_src_ref(cfg_src_ref), .cfg_src_adv(cfg_src_adv),
        .cfg_edge_pol(cfg_edge_pol), .cfg_pause_on(cfg_pause_on),
        .cfg_pause_lvl(cfg_pause_lvl), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
        .cfg_nrec(cfg_nrec), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_rec(wr_rec), .evt_rdy_start(evt_rdy_start), .evt_rdy_adv(evt_rdy_adv),
        .evt_eor(evt_eor), .eor_ref_addr(eor_ref_addr)
    );

    int n_chk = 0, n_fail = 0;
    int n_wr = 0, n_eor = 0, n_rs = 0, n_ra = 0, last_ref = -1, last_rec = -1;

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin n_wr++; last_rec = int'(wr_rec); end
            if (evt_eor) begin n_eor++; last_ref = int'(eor_ref_addr); end
            if (evt_rdy_start) n_rs++;
            if (evt_rdy_adv) n_ra++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int i);
        trg_sw[i] = 1'b1;
        @(negedge clk);
        trg_sw[i] = 1'b0;
    endtask

    task automatic feed(input int n);
        for (int k = 0; k < n; k++) begin
            smp_en = 1'b1;
            smp_data = smp_data + 8'd1;
            @(negedge clk);
        end
        smp_en = 1'b0;
    endtask

    // rows: pre, post, fill before reference, expected reference address, expected writes
    localparam int ROWS = 6;
    localparam int TAB [ROWS][5] = '{
        '{0,  1,  0, 0,  1},
        '{3,  4,  3, 3,  7},
        '{3,  4, 20, 4, 24},
        '{16, 0, 16, 0, 16},
        '{5, 11,  9, 9, 20},
        '{0, 16,  0, 0, 16}
    };

    initial begin
        int w0, e0, s0, a0;
        cyc(1);
        chk("R3 reset wr_en", int'(wr_en), 0);
        chk("R5 reset eor", int'(evt_eor), 0);
        cyc(2);
        rst = 1'b0;
        cyc(3);
        chk("R7 ready after reset", n_rs, 1);

        // table walk: software start and reference, single record
        for (int r = 0; r < ROWS; r++) begin
            cfg_pre = (AW+1)'(TAB[r][0]);
            cfg_post = (AW+1)'(TAB[r][1]);
            w0 = n_wr; e0 = n_eor; s0 = n_rs;
            pulse(0); cyc(1);
            feed(TAB[r][2]);
            pulse(1);
            feed(TAB[r][1] + 2);
            cyc(3);
            chk("R3/R4 writes per record", n_wr - w0, TAB[r][4]);
            chk("R5 reference address", last_ref, TAB[r][3]);
            chk("R5 one close", n_eor - e0, 1);
            chk("R7 back to ready", n_rs - s0, 1);
        end

        // R2: early reference ignored
        cfg_pre = 5'd4; cfg_post = 5'd2;
        w0 = n_wr; e0 = n_eor;
        pulse(0); cyc(1);
        feed(2); pulse(1); cyc(2);
        chk("R2 early reference no close", n_eor - e0, 0);
        feed(2); pulse(1); feed(4); cyc(3);
        chk("R2 writes after late reference", n_wr - w0, 6);
        chk("R2 reference address", last_ref, 4);

        // R6 pause, R9 reference off
        cfg_src_ref = 2'b10; cfg_pre = '0; cfg_post = 5'd4;
        cfg_pause_on = 1'b1; cfg_pause_lvl = 1'b1;
        w0 = n_wr; e0 = n_eor;
        pulse(0);
        trg_hw[3] = 1'b1; cyc(4);
        feed(5); cyc(2);
        chk("R6 paused no writes", n_wr - w0, 0);
        trg_hw[3] = 1'b0; cyc(4);
        feed(4); cyc(3);
        chk("R6 writes after pause", n_wr - w0, 4);
        chk("R9 reference off closes", n_eor - e0, 1);
        cfg_pause_on = 1'b0;

        // R1 hardware start, falling edge
        cfg_src_start = 2'b00; cfg_edge_pol = 3'b110; cfg_post = 5'd2;
        w0 = n_wr;
        trg_hw[0] = 1'b1; cyc(4);
        feed(2); cyc(2);
        chk("R1 rising edge ignored for falling start", n_wr - w0, 0);
        trg_hw[0] = 1'b0; cyc(4);
        feed(2); cyc(3);
        chk("R1 falling start captures", n_wr - w0, 2);
        cfg_src_start = 2'b01;

        // R1 hardware reference, rising edge
        cfg_src_ref = 2'b00; cfg_pre = 5'd2; cfg_post = 5'd1;
        w0 = n_wr; e0 = n_eor;
        pulse(0); cyc(1);
        feed(3);
        trg_hw[1] = 1'b1; cyc(4);
        feed(2); cyc(3);
        chk("R1 rising reference writes", n_wr - w0, 4);
        chk("R1 rising reference address", last_ref, 3);
        trg_hw[1] = 1'b0; cyc(3);

        // R8/R10 multi-record with advance
        cfg_src_ref = 2'b10; cfg_src_adv = 2'b01; cfg_pre = '0; cfg_post = 5'd2;
        cfg_nrec = 31'd3;
        w0 = n_wr; e0 = n_eor; s0 = n_rs; a0 = n_ra;
        pulse(0); cyc(1); feed(2); cyc(3);
        chk("R8 ready for advance", n_ra - a0, 1);
        feed(3); cyc(2);
        chk("R8 samples ignored in wait", n_wr - w0, 2);
        pulse(2); cyc(1); feed(2); cyc(3);
        pulse(2); cyc(1); feed(2); cyc(3);
        feed(2); cyc(2);
        chk("R7 three records written", n_wr - w0, 6);
        chk("R7 three closes", n_eor - e0, 3);
        chk("R8 two advance events", n_ra - a0, 2);
        chk("R7 ready for start at end", n_rs - s0, 1);
        chk("R10 last record index", last_rec, 2);

        // R9 advance off
        cfg_src_adv = 2'b10; cfg_post = 5'd1; cfg_nrec = 31'd2;
        w0 = n_wr; e0 = n_eor; a0 = n_ra;
        pulse(0); cyc(1); feed(1); cyc(4); feed(1); cyc(3);
        chk("R9 advance off two closes", n_eor - e0, 2);
        chk("R9 advance off no wait event", n_ra - a0, 0);
        chk("R9 advance off writes", n_wr - w0, 2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule